// File: doc/BRIEF.md
# Weight-Stationary Systolic Multiply-Accumulate Array

This block is a square grid of N by N multiply-accumulate cells. Each cell takes a signed weight during a loading phase and holds it. The array then enters compute mode. Activation vectors are presented on the input port, one per cycle. Inside the grid, activations travel rightward along the rows. Partial sums travel downward along the columns. Each cell adds the product of its weight and the activation passing through it to the sum coming from the cell above.

Weights arrive one row vector per cycle through a dedicated load port. Rows shift down the grid as each new vector enters at the top. A single done pulse then switches the array to compute mode. The array keeps the same weights for any number of activation vectors, which pays off when many vectors share one weight set.

The input side skews each row by its row index. The output side deskews each column, so a complete result vector leaves the array in one cycle. Results come out at one vector per cycle, with a fixed latency and with a valid flag.

Top module: `ws_systolic_array`

## Requirements
- R1: After reset, out_valid is low, out_vec is all zeros, every weight is zero, and the array is in weight-load mode.
- R2: Each load vector that is accepted enters the top row, with lane c of wload_row (bits c*8 upward) going to column c. In the same cycle every row already loaded moves down by one row. After N accepted loads, the k-th vector (counting from 0) sits in row N-1-k.
- R3: In weight-load mode, act_valid is ignored and produces no result. A cycle with wload_done high switches the array to compute mode, and activations are accepted from the next cycle on. If wload_valid and wload_done are high in the same cycle, both take effect.
- R4: Take an accepted vector x, where lane r of act_vec (bits r*8 upward) is the signed 8-bit value x_r. Lane c of out_vec (bits c*32 upward) equals the sum over r of W[r][c]*x_r, where each W[r][c] is a signed 8-bit weight. The result is a signed 32-bit two's-complement value.
- R5: A vector sampled on rising edge e appears on rising edge e+2N-2, with out_valid high. All lanes appear together. For N=4 the offset is 6 edges.
- R6: Vectors accepted on consecutive cycles produce results on consecutive cycles, in the same order. The out_valid pattern repeats the pattern of accepted vectors.
- R7: Whenever out_valid is low, out_vec is all zeros.
- R8: In compute mode, a load request (wload_valid high) is ignored in two cases: while any accepted vector has not yet appeared at the output, or while act_valid is high in the same cycle. When ignored, no weight changes and the array stays in compute mode.
- R9: In compute mode, a load request is accepted as a first row shift if nothing is in flight and act_valid is low. Acceptance returns the array to weight-load mode, where activations are ignored again until the next wload_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wload_valid | input | 1 | Load-port row vector is present |
| wload_row | input | N*WW | One weight per column, lane c = column c |
| wload_done | input | 1 | Pulse: end of weight loading, enter compute mode |
| act_valid | input | 1 | Activation vector is present |
| act_vec | input | N*AW | One activation per row, lane r = row r |
| out_valid | output | 1 | Result vector is present |
| out_vec | output | N*SW | One 32-bit sum per column, lane c = column c |

## Verification
Unit vectors sent one at a time return single weight rows, one per vector. This pattern separates a correct row placement from a swapped or reversed shift order. One isolated vector measures the latency alone. A burst of pseudo-random vectors shows whether results stay in order and stay back-to-back. Full-scale positive and negative operands expose sign-extension and accumulator-width faults. Load requests sent while vectors are in flight, and activations sent during loading, show whether the mode rules keep the weights and the results unchanged.

// File: rtl/sa_pkg.sv
package sa_pkg;

   // operating mode of the grid
   typedef enum logic {
      SA_LOAD = 1'b0,
      SA_RUN  = 1'b1
   } sa_mode_e;

   // width a column sum needs for rows of signed products
   function automatic int sum_need(input int ww, input int aw, input int rows);
      return ww + aw + $clog2(rows);
   endfunction

endpackage

// File: rtl/sa_delay.sv
module sa_delay #(
   parameter int W = 8,
   parameter int D = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (D < 1) begin : g_bad_depth
         $error("sa_delay: depth must be at least one");
      end
      if (W < 1) begin : g_bad_width
         $error("sa_delay: width must be at least one");
      end
   endgenerate

   logic [W-1:0] stg [D];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < D; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < D; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[D-1];

endmodule

// File: rtl/sa_pe.sv
module sa_pe #(
   parameter int WW = 8,
   parameter int AW = 8,
   parameter int SW = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 w_shift,
   input  logic signed [WW-1:0] w_in,
   output logic signed [WW-1:0] w_q,
   input  logic signed [AW-1:0] a_in,
   output logic signed [AW-1:0] a_q,
   input  logic signed [SW-1:0] ps_in,
   output logic signed [SW-1:0] ps_q
);

   localparam int PW = WW + AW;

   generate
      if (SW < PW) begin : g_bad_sum
         $error("sa_pe: sum width below product width");
      end
   endgenerate

   logic signed [PW-1:0] prod;
   logic signed [SW-1:0] prod_x;

   assign prod   = w_q * a_in;
   assign prod_x = SW'(prod);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         w_q  <= '0;
         a_q  <= '0;
         ps_q <= '0;
      end else begin
         if (w_shift) w_q <= w_in;
         a_q  <= a_in;
         ps_q <= ps_in + prod_x;
      end
   end

endmodule

// File: rtl/sa_ctrl.sv
module sa_ctrl
   import sa_pkg::*;
#(
   parameter int N = 4
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wload_valid,
   input  logic     wload_done,
   input  logic     act_valid,
   output logic     w_shift,
   output logic     act_take,
   output sa_mode_e mode,
   output logic     out_valid
);

   localparam int LAT = 2 * N - 1;

   sa_mode_e         mode_q, mode_d;
   logic [LAT-1:0]   vld_q;
   logic             busy;

   assign busy     = |vld_q;
   assign act_take = (mode_q == SA_RUN) && act_valid;

   always_comb begin
      w_shift = 1'b0;
      mode_d  = mode_q;
      unique case (mode_q)
         SA_LOAD: begin
            w_shift = wload_valid;
            if (wload_done) mode_d = SA_RUN;
         end
         SA_RUN: begin
            if (wload_valid && !act_valid && !busy) begin
               w_shift = 1'b1;
               mode_d  = SA_LOAD;
            end
         end
         default: mode_d = SA_LOAD;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= SA_LOAD;
         vld_q  <= '0;
      end else begin
         mode_q <= mode_d;
         vld_q  <= {vld_q[LAT-2:0], act_take};
      end
   end

   assign mode      = mode_q;
   assign out_valid = vld_q[LAT-1];

   // R3
   no_take_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == SA_LOAD) |=> !vld_q[0]);

   // R9
   load_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == SA_RUN && w_shift) |=> (mode_q == SA_LOAD));

endmodule

// File: rtl/ws_systolic_array.sv
module ws_systolic_array
   import sa_pkg::*;
#(
   parameter int N  = 4,
   parameter int WW = 8,
   parameter int AW = 8,
   parameter int SW = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wload_valid,
   input  logic [N*WW-1:0] wload_row,
   input  logic            wload_done,
   input  logic            act_valid,
   input  logic [N*AW-1:0] act_vec,
   output logic            out_valid,
   output logic [N*SW-1:0] out_vec
);

   generate
      if (N < 2) begin : g_bad_n
         $error("ws_systolic_array: grid needs at least two rows");
      end
      if (SW < sum_need(WW, AW, N)) begin : g_bad_sw
         $error("ws_systolic_array: sum width can overflow");
      end
   endgenerate

   logic            w_shift;
   logic            act_take;
   sa_mode_e        mode;
   logic [N*AW-1:0] act_g;

   sa_ctrl #(.N(N)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wload_valid(wload_valid),
      .wload_done (wload_done),
      .act_valid  (act_valid),
      .w_shift    (w_shift),
      .act_take   (act_take),
      .mode       (mode),
      .out_valid  (out_valid)
   );

   assign act_g = act_take ? act_vec : '0;

   logic signed [WW-1:0] w_src [N][N];
   logic signed [WW-1:0] wq    [N][N];
   logic signed [AW-1:0] ac    [N][N+1];
   logic signed [SW-1:0] ps    [N+1][N];
   logic        [SW-1:0] res   [N];

   genvar r, c;
   generate
      // left edge: row r waits r cycles
      for (r = 0; r < N; r++) begin : g_skew
         if (r == 0) begin : g_direct
            assign ac[0][0] = act_g[AW-1:0];
         end else begin : g_line
            sa_delay #(.W(AW), .D(r)) u_skew (
               .clk  (clk),
               .rst_n(rst_n),
               .d    (act_g[r*AW +: AW]),
               .q    (ac[r][0])
            );
         end
      end

      for (c = 0; c < N; c++) begin : g_top
         assign ps[0][c] = '0;
      end

      for (r = 0; r < N; r++) begin : g_row
         for (c = 0; c < N; c++) begin : g_col
            if (r == 0) begin : g_wfeed
               assign w_src[r][c] = wload_row[c*WW +: WW];
            end else begin : g_wchain
               assign w_src[r][c] = wq[r-1][c];
            end
            sa_pe #(.WW(WW), .AW(AW), .SW(SW)) u_pe (
               .clk    (clk),
               .rst_n  (rst_n),
               .w_shift(w_shift),
               .w_in   (w_src[r][c]),
               .w_q    (wq[r][c]),
               .a_in   (ac[r][c]),
               .a_q    (ac[r][c+1]),
               .ps_in  (ps[r][c]),
               .ps_q   (ps[r+1][c])
            );
         end
      end

      // bottom edge: column c waits N-1-c cycles
      for (c = 0; c < N; c++) begin : g_deskew
         if (c == N - 1) begin : g_direct
            assign res[c] = ps[N][c];
         end else begin : g_line
            sa_delay #(.W(SW), .D(N - 1 - c)) u_dsk (
               .clk  (clk),
               .rst_n(rst_n),
               .d    (ps[N][c]),
               .q    (res[c])
            );
         end
         assign out_vec[c*SW +: SW] = res[c];
      end
   endgenerate

   logic unused_tail;
   always_comb begin
      unused_tail = 1'b0;
      for (int i = 0; i < N; i++) begin
         unused_tail = unused_tail ^ (^wq[N-1][i]) ^ (^ac[i][N]);
      end
   end

   // R7
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_vec == '0));

   // R8
   compute_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (mode == SA_RUN));

endmodule

// File: tb/sim_ws_systolic_array.sv
`timescale 1ns/1ps
module sim_ws_systolic_array;

   localparam int N   = 4;
   localparam int WW  = 8;
   localparam int AW  = 8;
   localparam int SW  = 32;
   localparam int LAT = 2 * N - 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wload_valid = 1'b0;
   logic [N*WW-1:0] wload_row = '0;
   logic            wload_done = 1'b0;
   logic            act_valid = 1'b0;
   logic [N*AW-1:0] act_vec = '0;
   logic            out_valid;
   logic [N*SW-1:0] out_vec;

   always #4 clk = ~clk;

   ws_systolic_array #(.N(N), .WW(WW), .AW(AW), .SW(SW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .wload_valid(wload_valid), .wload_row(wload_row), .wload_done(wload_done),
      .act_valid(act_valid), .act_vec(act_vec),
      .out_valid(out_valid), .out_vec(out_vec)
   );

   int    checks = 0;
   int    errors = 0;
   bit    finished = 0;
   string cur_tag = "R1";

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [N*SW-1:0] act, input logic [N*SW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // ---------------- behavioural reference ----------------
   int                wm [N][N];
   bit                m_run = 0;
   int                edge_n = 0;
   int                last_due = -100;
   int                due_q [$];
   logic [N*SW-1:0]   exp_q [$];
   bit                mon_on = 0;
   int                vrun = 0;
   int                max_run = 0;

   always @(posedge clk) begin
      if (rst_n) begin
         bit busy;
         edge_n++;
         busy = (last_due >= edge_n - 1);
         if (!m_run) begin
            if (wload_valid) begin
               for (int r = N - 1; r > 0; r--)
                  for (int c = 0; c < N; c++) wm[r][c] = wm[r-1][c];
               for (int c = 0; c < N; c++) wm[0][c] = $signed(wload_row[c*WW +: WW]);
            end
            if (wload_done) m_run = 1;
         end else if (act_valid) begin
            logic [N*SW-1:0] e;
            for (int c = 0; c < N; c++) begin
               int s;
               s = 0;
               for (int r = 0; r < N; r++) s += wm[r][c] * int'($signed(act_vec[r*AW +: AW]));
               e[c*SW +: SW] = s;
            end
            due_q.push_back(edge_n + 2 * N - 2);
            exp_q.push_back(e);
            last_due = edge_n + 2 * N - 2;
         end else if (wload_valid && !busy) begin
            for (int r = N - 1; r > 0; r--)
               for (int c = 0; c < N; c++) wm[r][c] = wm[r-1][c];
            for (int c = 0; c < N; c++) wm[0][c] = $signed(wload_row[c*WW +: WW]);
            m_run = 0;
         end
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (mon_on) begin
         if (due_q.size() > 0 && due_q[0] == edge_n) begin
            chk(out_valid === 1'b1, cur_tag, "valid (R5 timing)", {{(N*SW-1){1'b0}}, out_valid}, 1);
            chk(out_vec === exp_q[0], cur_tag, "result (R4)", out_vec, exp_q[0]);
            void'(due_q.pop_front());
            void'(exp_q.pop_front());
         end else begin
            chk(out_valid === 1'b0, cur_tag, "spurious valid", {{(N*SW-1){1'b0}}, out_valid}, 0);
            chk(out_vec === '0, cur_tag, "idle zero (R7)", out_vec, '0);
         end
         if (out_valid) begin
            vrun++;
            if (vrun > max_run) max_run = vrun;
         end else vrun = 0;
      end
   end

   // ---------------- stimulus helpers ----------------
   int wset [N][N];
   int seed = 32'h1357_9bdf;

   function automatic int rnd8();
      seed = seed * 1103515245 + 12345;
      return ((seed >>> 16) & 255) - 128;
   endfunction

   task automatic load_matrix(input bit with_done);
      for (int k = 0; k < N; k++) begin
         wload_valid = 1'b1;
         for (int c = 0; c < N; c++) wload_row[c*WW +: WW] = WW'(wset[N-1-k][c]);
         @(negedge clk);
      end
      wload_valid = 1'b0;
      if (with_done) begin
         wload_done = 1'b1;
         @(negedge clk);
         wload_done = 1'b0;
      end
   endtask

   task automatic put_vec(input int x0, input int x1, input int x2, input int x3);
      act_valid = 1'b1;
      act_vec = {AW'(x3), AW'(x2), AW'(x1), AW'(x0)};
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      act_valid = 1'b0;
      act_vec = '0;
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         report();
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(out_valid === 1'b0, "R1", "valid in reset", {{(N*SW-1){1'b0}}, out_valid}, 0);
      chk(out_vec === '0, "R1", "out in reset", out_vec, '0);
      rst_n = 1'b1;
      mon_on = 1;
      cur_tag = "R1";
      idle(3);

      // R3: activations before any done pulse are ignored
      cur_tag = "R3";
      put_vec(5, -3, 7, 1);
      put_vec(100, 100, 100, 100);
      put_vec(-1, 2, -3, 4);
      idle(LAT + 2);

      // R2: load distinct weights, unit vectors pick one weight row each
      cur_tag = "R2";
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++)
            wset[r][c] = ((c % 2) ? -3 : 3) * (r * N + c + 1);
      load_matrix(1);
      for (int r = 0; r < N; r++) begin
         put_vec(r == 0, r == 1, r == 2, r == 3);
         idle(2);
      end
      idle(LAT);

      // R5: single isolated vector latency
      cur_tag = "R5";
      begin
         int k;
         act_valid = 1'b1;
         act_vec = {8'sd2, -8'sd5, 8'sd9, 8'sd1};
         @(negedge clk);
         act_valid = 1'b0;
         act_vec = '0;
         k = 1;
         while (!out_valid && k < 50) begin
            @(negedge clk);
            k++;
         end
         chk(k == LAT, "R5", "latency in cycles", k, LAT);
      end
      idle(LAT);

      // R6: back-to-back burst
      cur_tag = "R6";
      max_run = 0;
      for (int i = 0; i < 8; i++) put_vec(rnd8(), rnd8(), rnd8(), rnd8());
      idle(LAT + 2);
      chk(max_run == 8, "R6", "consecutive valid outputs", max_run, 8);

      // R6 gapped pattern
      for (int i = 0; i < 6; i++) begin
         put_vec(rnd8(), rnd8(), rnd8(), rnd8());
         if (i % 2) idle(1);
      end
      idle(LAT + 2);

      // R8: load requests while vectors in flight are ignored
      cur_tag = "R8";
      for (int i = 0; i < 6; i++) begin
         if (i >= 2) begin
            wload_valid = 1'b1;
            wload_row = {8'sd77, 8'sd77, 8'sd77, 8'sd77};
         end
         put_vec(rnd8(), rnd8(), rnd8(), rnd8());
      end
      wload_valid = 1'b1;
      act_valid = 1'b0;
      @(negedge clk);
      wload_valid = 1'b0;
      wload_done = 1'b1;
      @(negedge clk);
      wload_done = 1'b0;
      idle(LAT + 2);
      put_vec(1, 1, 1, 1);
      idle(LAT + 2);

      // R9: load after drain returns to load mode; activations ignored there
      cur_tag = "R9";
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++) wset[r][c] = rnd8();
      load_matrix(0);
      put_vec(9, 9, 9, 9);
      put_vec(-9, 4, 3, 2);
      act_valid = 1'b0;
      wload_done = 1'b1;
      @(negedge clk);
      wload_done = 1'b0;
      for (int i = 0; i < 4; i++) put_vec(rnd8(), rnd8(), rnd8(), rnd8());
      idle(LAT + 2);

      // R4: full-scale signed operands
      cur_tag = "R4";
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++) wset[r][c] = ((r + c) % 2) ? 127 : -128;
      load_matrix(1);
      put_vec(-128, -128, -128, -128);
      put_vec(127, 127, 127, 127);
      put_vec(-128, 127, -128, 127);
      put_vec(0, 0, 0, 0);
      idle(LAT + 2);

      mon_on = 0;
      chk(due_q.size() == 0, "R6", "results left outstanding", due_q.size(), 0);
      report();
   end

endmodule